// File: doc/BRIEF.md
# Banked Register File with Select Register

This block holds the general-purpose register state of a processor core. It has a number of register banks, four by default. Every bank keeps two copies, primary and alternate, of the 16-bit accumulator/flag pair and of five 32-bit pairs: BC, DE and HL (general) and the two index pairs IX and IY. A 32-bit select register chooses the live bank and, for each group, whether the primary or the alternate copy is live. A single opcode port in the execute stage issues one action per cycle. The action can be a write by logical register name, a select-register update, a copy toggle, an exchange between the live copy of a pair and its other copy, or a swap of a pair's upper and lower 16-bit halves. A separate combinational read port returns any logical register of the live copies.

A long-word bit in the select register sets the width of pair transfers. With the bit clear, pair writes, reads and exchanges act on the low 16 bits only. With it set, they act on all 32 bits. Byte names reach the high and low bytes of the low 16 bits of each pair. Switching banks or copies takes one select-register update and moves no data.

Top module: `rbank_regfile`

## Requirements
- R1: Reset (synchronous, active high) clears the select register and every stored register to zero, so bank 0 primary copies are live and every read returns 0.
- R2: WRITE (op 1) with a byte name changes only that byte, and every read returns its value zero-extended. A and F are bits 15:8 and 7:0 of AF. B/C, D/E, H/L, IXU/IXL and IYU/IYL are bits 15:8 and 7:0 of BC, DE, HL, IX and IY.
- R3: Select bit 16 is the long-word bit. When it is 0, a pair write changes only bits 15:0 and keeps bits 31:16, and a pair read returns bits 15:0 zero-extended. When it is 1, both act on all 32 bits. AF is always 16 bits.
- R4: Select bits 9:8 give the live bank. A write in one bank is not visible from another bank.
- R5: X_AF (op 7), X_MAIN (op 8), X_IX (op 9) and X_IY (op 10) invert select bits 0, 1, 2 and 3 respectively. X_ALL (op 11) inverts all four bits. A bit at 1 makes the alternate copy of its group live (bit 1 covers BC, DE and HL).
- R6: X_PAIR (op 12) on a pair name exchanges the live copy with the other copy in the same bank. When the long-word bit is 0, only bits 15:0 move. When it is 1, all 32 bits move. AF exchanges 16 bits. The select register does not change.
- R7: SWAP (op 13) on BC, DE, HL, IX or IY exchanges bits 31:16 and 15:0 of the live copy. On AF or on a byte name it has no effect.
- R8: SR_ALL (op 2) loads all 32 select bits. SR_B1, SR_B2 and SR_B3 (ops 3 to 5) load only select byte 1, 2 or 3 from data bits 7:0. SR_BCAST (op 6) loads bytes 1, 2 and 3 with the same data byte and leaves byte 0 unchanged.
- R9: A read in the same cycle as a write to the same register returns the old value. The new value appears after the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Action code: 0 none, 1 write, 2-6 select writes, 7-11 toggles, 12 exchange, 13 half swap |
| op_sel_i | input | 5 | Logical register name that the action targets |
| op_data_i | input | 32 | Write data (select byte writes use bits 7:0) |
| rd_sel_i | input | 5 | Logical register name to read |
| rd_data_o | output | 32 | Read data from the live copy, zero-extended |
| sr_o | output | 32 | Current select register |

## Verification
The bench builds the block with the default of four banks, which gives a two-bit bank field. Moving between banks 0 and 1 therefore also shows that the upper bank bit stays clear and that the data of each bank stays separate. Both copies of the general group, the index pairs and AF are used in both width modes. This shows that word-mode exchanges keep the upper halves of both copies, while long-mode exchanges move all 32 bits.

// File: rtl/rbank_pkg.sv
package rbank_pkg;

    localparam int NPAIR       = 5;
    localparam int PAIR_BC     = 0;
    localparam int PAIR_DE     = 1;
    localparam int PAIR_HL     = 2;
    localparam int PAIR_IX     = 3;
    localparam int PAIR_IY     = 4;

    localparam int SR_AF_BIT   = 0;
    localparam int SR_MAIN_BIT = 1;
    localparam int SR_IX_BIT   = 2;
    localparam int SR_IY_BIT   = 3;
    localparam int SR_BANK_LSB = 8;
    localparam int SR_LONG_BIT = 16;

    typedef enum logic [4:0] {
        R_A   = 5'd0,  R_F   = 5'd1,  R_B   = 5'd2,  R_C   = 5'd3,
        R_D   = 5'd4,  R_E   = 5'd5,  R_H   = 5'd6,  R_L   = 5'd7,
        R_IXU = 5'd8,  R_IXL = 5'd9,  R_IYU = 5'd10, R_IYL = 5'd11,
        R_AF  = 5'd12, R_BC  = 5'd13, R_DE  = 5'd14, R_HL  = 5'd15,
        R_IX  = 5'd16, R_IY  = 5'd17
    } reg_id_e;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_WRITE    = 4'd1,
        OP_SR_ALL   = 4'd2,
        OP_SR_B1    = 4'd3,
        OP_SR_B2    = 4'd4,
        OP_SR_B3    = 4'd5,
        OP_SR_BCAST = 4'd6,
        OP_X_AF     = 4'd7,
        OP_X_MAIN   = 4'd8,
        OP_X_IX     = 4'd9,
        OP_X_IY     = 4'd10,
        OP_X_ALL    = 4'd11,
        OP_X_PAIR   = 4'd12,
        OP_SWAP     = 4'd13
    } op_e;

    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_HI   = 2'd1,
        K_LO   = 2'd2,
        K_FULL = 2'd3
    } lane_e;

    typedef struct packed {
        logic       is_af;
        logic [2:0] pair;
        lane_e      lane;
    } target_t;

    typedef logic [NPAIR-1:0][31:0] pair_vec_t;

    function automatic target_t decode_id(input reg_id_e id);
        target_t t;
        t.is_af = 1'b0;
        t.pair  = 3'd0;
        t.lane  = K_NONE;
        case (id)
            R_A:   begin t.is_af = 1'b1; t.lane = K_HI; end
            R_F:   begin t.is_af = 1'b1; t.lane = K_LO; end
            R_AF:  begin t.is_af = 1'b1; t.lane = K_FULL; end
            R_B:   begin t.pair = 3'(PAIR_BC); t.lane = K_HI; end
            R_C:   begin t.pair = 3'(PAIR_BC); t.lane = K_LO; end
            R_BC:  begin t.pair = 3'(PAIR_BC); t.lane = K_FULL; end
            R_D:   begin t.pair = 3'(PAIR_DE); t.lane = K_HI; end
            R_E:   begin t.pair = 3'(PAIR_DE); t.lane = K_LO; end
            R_DE:  begin t.pair = 3'(PAIR_DE); t.lane = K_FULL; end
            R_H:   begin t.pair = 3'(PAIR_HL); t.lane = K_HI; end
            R_L:   begin t.pair = 3'(PAIR_HL); t.lane = K_LO; end
            R_HL:  begin t.pair = 3'(PAIR_HL); t.lane = K_FULL; end
            R_IXU: begin t.pair = 3'(PAIR_IX); t.lane = K_HI; end
            R_IXL: begin t.pair = 3'(PAIR_IX); t.lane = K_LO; end
            R_IX:  begin t.pair = 3'(PAIR_IX); t.lane = K_FULL; end
            R_IYU: begin t.pair = 3'(PAIR_IY); t.lane = K_HI; end
            R_IYL: begin t.pair = 3'(PAIR_IY); t.lane = K_LO; end
            R_IY:  begin t.pair = 3'(PAIR_IY); t.lane = K_FULL; end
            default: ;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/rbank_selreg.sv
module rbank_selreg
    import rbank_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  op_e         op_i,
    input  logic [31:0] data_i,
    output logic [31:0] sr_o
);

    logic [31:0] sr_q;
    logic [7:0]  byte_in;

    assign byte_in = data_i[7:0];
    assign sr_o    = sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            case (op_i)
                OP_SR_ALL:   sr_q <= data_i;
                OP_SR_B1:    sr_q[15:8]  <= byte_in;
                OP_SR_B2:    sr_q[23:16] <= byte_in;
                OP_SR_B3:    sr_q[31:24] <= byte_in;
                OP_SR_BCAST: sr_q[31:8]  <= {3{byte_in}};
                OP_X_AF:     sr_q[SR_AF_BIT]   <= ~sr_q[SR_AF_BIT];
                OP_X_MAIN:   sr_q[SR_MAIN_BIT] <= ~sr_q[SR_MAIN_BIT];
                OP_X_IX:     sr_q[SR_IX_BIT]   <= ~sr_q[SR_IX_BIT];
                OP_X_IY:     sr_q[SR_IY_BIT]   <= ~sr_q[SR_IY_BIT];
                OP_X_ALL:    sr_q[3:0] <= ~sr_q[3:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rbank_store.sv
module rbank_store
    import rbank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              af_alt_i,
    input  logic [NPAIR-1:0]  pair_alt_i,
    input  logic              long_i,
    input  logic              wr_en_i,
    input  logic              xch_en_i,
    input  logic              swap_en_i,
    input  reg_id_e           id_i,
    input  logic [31:0]       data_i,
    output logic [15:0]       af_o,
    output pair_vec_t         pairs_o
);

    logic [15:0] af_q [NUM_BANKS][2];
    logic [31:0] pr_q [NUM_BANKS][2][NPAIR];

    target_t     tgt;
    logic [15:0] af_oth;
    logic [31:0] pr_act, pr_oth;
    logic        af_act_we, af_oth_we, pr_act_we, pr_oth_we;
    logic [15:0] af_act_nxt, af_oth_nxt;
    logic [31:0] pr_act_nxt, pr_oth_nxt;
    logic        tgt_copy;

    assign tgt = decode_id(id_i);

    // Live copy of every group in the selected bank
    always_comb begin
        af_o = af_q[bank_i][af_alt_i];
        for (int p = 0; p < NPAIR; p++) begin
            pairs_o[p] = pr_q[bank_i][pair_alt_i[p]][p];
        end
    end

    assign tgt_copy = pair_alt_i[tgt.pair];
    assign af_oth   = af_q[bank_i][~af_alt_i];
    assign pr_act   = pr_q[bank_i][tgt_copy][tgt.pair];
    assign pr_oth   = pr_q[bank_i][~tgt_copy][tgt.pair];

    always_comb begin
        af_act_we  = 1'b0;
        af_oth_we  = 1'b0;
        pr_act_we  = 1'b0;
        pr_oth_we  = 1'b0;
        af_act_nxt = af_o;
        af_oth_nxt = af_oth;
        pr_act_nxt = pr_act;
        pr_oth_nxt = pr_oth;
        if (tgt.is_af) begin
            if (wr_en_i && tgt.lane != K_NONE) begin
                af_act_we = 1'b1;
                case (tgt.lane)
                    K_HI:    af_act_nxt[15:8] = data_i[7:0];
                    K_LO:    af_act_nxt[7:0]  = data_i[7:0];
                    default: af_act_nxt       = data_i[15:0];
                endcase
            end else if (xch_en_i && tgt.lane == K_FULL) begin
                af_act_we  = 1'b1;
                af_oth_we  = 1'b1;
                af_act_nxt = af_oth;
                af_oth_nxt = af_o;
            end
        end else if (tgt.lane != K_NONE) begin
            if (wr_en_i) begin
                pr_act_we = 1'b1;
                case (tgt.lane)
                    K_HI:    pr_act_nxt[15:8] = data_i[7:0];
                    K_LO:    pr_act_nxt[7:0]  = data_i[7:0];
                    default: pr_act_nxt = long_i ? data_i
                                                 : {pr_act[31:16], data_i[15:0]};
                endcase
            end else if (xch_en_i && tgt.lane == K_FULL) begin
                pr_act_we = 1'b1;
                pr_oth_we = 1'b1;
                if (long_i) begin
                    pr_act_nxt = pr_oth;
                    pr_oth_nxt = pr_act;
                end else begin
                    pr_act_nxt = {pr_act[31:16], pr_oth[15:0]};
                    pr_oth_nxt = {pr_oth[31:16], pr_act[15:0]};
                end
            end else if (swap_en_i && tgt.lane == K_FULL) begin
                pr_act_we  = 1'b1;
                pr_act_nxt = {pr_act[15:0], pr_act[31:16]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                for (int c = 0; c < 2; c++) begin
                    af_q[b][c] <= '0;
                    for (int p = 0; p < NPAIR; p++) begin
                        pr_q[b][c][p] <= '0;
                    end
                end
            end
        end else begin
            if (af_act_we) af_q[bank_i][af_alt_i]  <= af_act_nxt;
            if (af_oth_we) af_q[bank_i][~af_alt_i] <= af_oth_nxt;
            if (pr_act_we) pr_q[bank_i][tgt_copy][tgt.pair]  <= pr_act_nxt;
            if (pr_oth_we) pr_q[bank_i][~tgt_copy][tgt.pair] <= pr_oth_nxt;
        end
    end

endmodule

// File: rtl/rbank_rdmux.sv
module rbank_rdmux
    import rbank_pkg::*;
(
    input  reg_id_e     id_i,
    input  logic        long_i,
    input  logic [15:0] af_i,
    input  pair_vec_t   pairs_i,
    output logic [31:0] data_o
);

    target_t     t;
    logic [31:0] word;

    assign t = decode_id(id_i);

    always_comb begin
        word = t.is_af ? {16'h0, af_i} : pairs_i[t.pair];
        case (t.lane)
            K_HI:    data_o = {24'h0, word[15:8]};
            K_LO:    data_o = {24'h0, word[7:0]};
            K_FULL:  data_o = (long_i && !t.is_af) ? word : {16'h0, word[15:0]};
            default: data_o = '0;
        endcase
    end

endmodule

// File: rtl/rbank_regfile.sv
module rbank_regfile
    import rbank_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [3:0]  op_i,
    input  logic [4:0]  op_sel_i,
    input  logic [31:0] op_data_i,
    input  logic [4:0]  rd_sel_i,
    output logic [31:0] rd_data_o,
    output logic [31:0] sr_o
);

    op_e               op;
    reg_id_e           op_id;
    reg_id_e           rd_id;
    logic [31:0]       sr;
    logic [BANK_W-1:0] bank;
    logic              long_mode;
    logic [NPAIR-1:0]  pair_alt;
    logic [15:0]       af_live;
    pair_vec_t         pairs_live;

    assign op        = op_e'(op_i);
    assign op_id     = reg_id_e'(op_sel_i);
    assign rd_id     = reg_id_e'(rd_sel_i);
    assign bank      = sr[SR_BANK_LSB +: BANK_W];
    assign long_mode = sr[SR_LONG_BIT];
    assign sr_o      = sr;

    // Copy selection per pair: BC/DE/HL share one bit, IX and IY have their own
    generate
        for (genvar p = 0; p < NPAIR; p++) begin : g_alt
            if (p == PAIR_IX) begin : g_ix
                assign pair_alt[p] = sr[SR_IX_BIT];
            end else if (p == PAIR_IY) begin : g_iy
                assign pair_alt[p] = sr[SR_IY_BIT];
            end else begin : g_main
                assign pair_alt[p] = sr[SR_MAIN_BIT];
            end
        end
    endgenerate

    rbank_selreg u_sel (
        .clk    (clk),
        .rst    (rst),
        .op_i   (op),
        .data_i (op_data_i),
        .sr_o   (sr)
    );

    rbank_store #(.NUM_BANKS(NUM_BANKS)) u_store (
        .clk        (clk),
        .rst        (rst),
        .bank_i     (bank),
        .af_alt_i   (sr[SR_AF_BIT]),
        .pair_alt_i (pair_alt),
        .long_i     (long_mode),
        .wr_en_i    (op == OP_WRITE),
        .xch_en_i   (op == OP_X_PAIR),
        .swap_en_i  (op == OP_SWAP),
        .id_i       (op_id),
        .data_i     (op_data_i),
        .af_o       (af_live),
        .pairs_o    (pairs_live)
    );

    rbank_rdmux u_rd (
        .id_i    (rd_id),
        .long_i  (long_mode),
        .af_i    (af_live),
        .pairs_i (pairs_live),
        .data_o  (rd_data_o)
    );

endmodule

// File: rtl/rbank_regfile_chk.sv
module rbank_regfile_chk
    import rbank_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [3:0]  op_i,
    input logic [4:0]  sel_i,
    input logic [7:0]  dbyte_i,
    input logic [31:0] sr_i,
    input logic [31:0] hl_i
);

    logic rst_d = 1'b0;
    always_ff @(posedge clk) rst_d <= rst;

    // R1: the cycle after reset the select register reads zero
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst_d |-> (sr_i == 32'h0));

    // R5: combined toggle inverts all four copy bits
    assert_xall_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_X_ALL) |=> (sr_i[3:0] == ~$past(sr_i[3:0])));

    // R5: single toggle touches only its own bit
    assert_xaf_only_R5: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_X_AF) |=> (sr_i[0] != $past(sr_i[0])) && (sr_i[3:1] == $past(sr_i[3:1])));

    // R3: word-mode write keeps the upper half of HL
    assert_word_write_upper_R3: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_WRITE && sel_i == R_HL && !sr_i[SR_LONG_BIT])
        |=> (hl_i[31:16] == $past(hl_i[31:16])));

    // R6: pair exchange leaves the select register alone
    assert_xpair_sr_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_X_PAIR) |=> $stable(sr_i));

    // R7: half swap of HL
    assert_swap_halves_R7: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SWAP && sel_i == R_HL)
        |=> (hl_i == {$past(hl_i[15:0]), $past(hl_i[31:16])}));

    // R8: broadcast fills bytes 1..3 and keeps byte 0
    assert_bcast_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SR_BCAST)
        |=> (sr_i[31:8] == {3{$past(dbyte_i)}}) && (sr_i[7:0] == $past(sr_i[7:0])));

    // R8: byte 1 write leaves the other bytes stable
    assert_byte1_only_R8: assert property (@(posedge clk) disable iff (rst)
        (op_i == OP_SR_B1)
        |=> (sr_i[15:8] == $past(dbyte_i)) && (sr_i[31:16] == $past(sr_i[31:16]))
            && (sr_i[7:0] == $past(sr_i[7:0])));

endmodule

bind rbank_regfile rbank_regfile_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_i    (op_i),
    .sel_i   (op_sel_i),
    .dbyte_i (op_data_i[7:0]),
    .sr_i    (sr),
    .hl_i    (pairs_live[2])
);

// File: tb/tb_rbank_regfile.sv
`timescale 1ns/1ps
module tb_rbank_regfile;
    import rbank_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  op_i = '0;
    logic [4:0]  op_sel_i = '0;
    logic [31:0] op_data_i = '0;
    logic [4:0]  rd_sel_i = '0;
    logic [31:0] rd_data_o;
    logic [31:0] sr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    rbank_regfile dut (
        .clk       (clk),
        .rst       (rst),
        .op_i      (op_i),
        .op_sel_i  (op_sel_i),
        .op_data_i (op_data_i),
        .rd_sel_i  (rd_sel_i),
        .rd_data_o (rd_data_o),
        .sr_o      (sr_o)
    );

    typedef struct packed {
        op_e         op;
        reg_id_e     sel;
        logic [31:0] data;
        reg_id_e     rsel;
        logic [31:0] exp;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{OP_WRITE,    R_A,   32'h12,       R_A,   32'h12},        // R2
        '{OP_WRITE,    R_F,   32'h34,       R_AF,  32'h1234},      // R2
        '{OP_WRITE,    R_HL,  32'hAAAA5678, R_HL,  32'h5678},      // R3
        '{OP_SR_B2,    R_A,   32'h01,       R_HL,  32'h00005678},  // R3
        '{OP_WRITE,    R_HL,  32'hCAFE5678, R_HL,  32'hCAFE5678},  // R3
        '{OP_SR_B2,    R_A,   32'h00,       R_HL,  32'h5678},      // R3
        '{OP_WRITE,    R_HL,  32'h00001111, R_HL,  32'h1111},      // R3
        '{OP_SR_B2,    R_A,   32'h01,       R_HL,  32'hCAFE1111},  // R3
        '{OP_SWAP,     R_HL,  32'h0,        R_HL,  32'h1111CAFE},  // R7
        '{OP_X_MAIN,   R_A,   32'h0,        R_HL,  32'h0},         // R5
        '{OP_WRITE,    R_HL,  32'h22223333, R_HL,  32'h22223333},  // R5
        '{OP_SR_B2,    R_A,   32'h00,       R_HL,  32'h3333},      // R3
        '{OP_X_PAIR,   R_HL,  32'h0,        R_HL,  32'hCAFE},      // R6
        '{OP_X_MAIN,   R_A,   32'h0,        R_HL,  32'h3333},      // R6
        '{OP_SR_B2,    R_A,   32'h01,       R_HL,  32'h11113333},  // R6
        '{OP_X_PAIR,   R_HL,  32'h0,        R_HL,  32'h2222CAFE},  // R6
        '{OP_WRITE,    R_IXU, 32'hAB,       R_IX,  32'h0000AB00},  // R2
        '{OP_WRITE,    R_IXL, 32'hCD,       R_IX,  32'h0000ABCD},  // R2
        '{OP_X_IX,     R_A,   32'h0,        R_IX,  32'h0},         // R5
        '{OP_X_IX,     R_A,   32'h0,        R_IXU, 32'hAB},        // R5
        '{OP_SR_B1,    R_A,   32'h01,       R_HL,  32'h0},         // R4
        '{OP_WRITE,    R_HL,  32'h0BADF00D, R_HL,  32'h0BADF00D},  // R4
        '{OP_SR_B1,    R_A,   32'h00,       R_HL,  32'h2222CAFE},  // R4
        '{OP_X_ALL,    R_A,   32'h0,        R_A,   32'h0},         // R5
        '{OP_X_ALL,    R_A,   32'h0,        R_A,   32'h12},        // R5
        '{OP_SWAP,     R_AF,  32'h0,        R_AF,  32'h1234},      // R7
        '{OP_X_AF,     R_A,   32'h0,        R_AF,  32'h0},         // R5
        '{OP_X_AF,     R_A,   32'h0,        R_AF,  32'h1234}       // R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic step(input op_e op, input reg_id_e sel, input logic [31:0] data,
                        input reg_id_e rsel);
        @(negedge clk);
        op_i      = op;
        op_sel_i  = sel;
        op_data_i = data;
        @(posedge clk);
        #1;
        op_i     = OP_NOP;
        rd_sel_i = rsel;
        #0.5;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd_sel_i = R_HL;
        #0.5;
        check("R1 reset select", sr_o, 32'h0);
        check("R1 reset read", rd_data_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].op, VEC[i].sel, VEC[i].data, VEC[i].rsel);
            check($sformatf("vector %0d", i), rd_data_o, VEC[i].exp);
        end

        // R8: whole, broadcast and single-byte select writes
        step(OP_SR_ALL, R_A, 32'h0301000A, R_A);
        check("R8 whole write", sr_o, 32'h0301000A);
        step(OP_SR_BCAST, R_A, 32'h00, R_A);
        check("R8 broadcast", sr_o, 32'h0000000A);
        step(OP_SR_B3, R_A, 32'h5A, R_A);
        check("R8 byte3 write", sr_o, 32'h5A00000A);
        step(OP_X_ALL, R_A, 32'h0, R_AF);
        check("R5 toggle bits", sr_o, 32'h5A000005);
        check("R5 alternate AF live", rd_data_o, 32'h0);

        // R9: read during a write sees the old value
        @(negedge clk);
        op_i = OP_WRITE; op_sel_i = R_B; op_data_i = 32'h77; rd_sel_i = R_B;
        #0.5;
        check("R9 old value", rd_data_o, 32'h0);
        @(posedge clk);
        #1;
        op_i = OP_NOP;
        check("R9 new value", rd_data_o, 32'h77);

        // R1: reset in mid run
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        rd_sel_i = R_B;
        #0.5;
        check("R1 select cleared", sr_o, 32'h0);
        check("R1 storage cleared", rd_data_o, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule